// File: doc/BRIEF.md
# Double-Buffered Peripheral DMA Channel

This block moves data words between system memory and one on-chip peripheral. It holds two buffer slots, each with its own byte count and memory address. Software fills one slot while the channel drains the other. The channel serves the slots in strict alternation. It shows how many buffers it holds through a four-value channel state, and it raises a level interrupt when buffers drain or the peripheral reports an error.

A parameter fixes the direction. In transmit, each peripheral request reads one word from memory and hands it to the peripheral. In receive, each request writes the peripheral's word into memory. Memory answers in the same cycle as the access. The acknowledge to the peripheral goes out in the cycle the word moves. Control goes through a small register bus. Writes take effect at the clock edge and reads are combinational.

Top module: `pdma_channel`

## Requirements
- R1: After reset, every readable register reads zero, the state is idle, `irq` is low and `perAck` stays low whatever `perReq` does.
- R2: The state sits in bits [5:4] of the status register (offset 0x0C), coded as idle=0, stall=1, on=2 and next=3. Writing control (offset 0x00) with bit 4 set moves idle to stall at that edge. Clearing bit 4 in stall returns the channel to idle at that edge. No transfer is acknowledged in idle or stall.
- R3: A write to a slot's address register marks that slot loaded only when the channel is enabled, the slot is empty and the state is not next. The address registers are at 0x24 for slot 0 and 0x34 for slot 1. An accepted write moves stall to on, or on to next. Any other write to these registers changes nothing.
- R4: A write to a slot's count register (0x20 for slot 0, 0x30 for slot 1) is stored only while that slot is empty.
- R5: Each cycle that `perReq` is high while the active slot holds a non-zero count moves one word. In that cycle `perAck` and `memEn` are high and `memAddr` is the slot's current address. The address then advances by DATA_W/8. The count drops by DATA_W/8, but never below zero. The remaining-count register (0x14) shows the active slot's count.
- R6: With IS_RX=0, `memWe` is low and `perWdata` equals `memRdata`. With IS_RX=1, `memWe` is high and `memWdata` equals `perRdata`.
- R7: Slot 0 is served first after each enable from idle. When the active slot's count reaches zero, the slot is released on the next edge and service switches to the other slot.
- R8: The interrupt register is at 0x04. Bit 0 is high whenever the state is stall. Bit 1 is set when a slot completes while the other slot is still loaded, which moves next to on. A completion in on with nothing else loaded moves the channel to stall.
- R9: A high `perErr` sets interrupt bit 3. Writing 1 to bit 3 clears it, but a new error in the same cycle wins.
- R10: `irq` is high exactly when an interrupt bit is set and its enable is set. The enables are control bits 0 (stall), 1 (next-buffer) and 3 (error).
- R11: Interrupt bit 1 is cleared by writing 1 to it or by an accepted address write.
- R12: If the active slot completes in the same cycle as an accepted load of the other slot, the state stays on, bit 1 stays clear and service moves to the newly loaded slot.
- R13: Clearing the enable while buffers are loaded lets them drain. The last completion then goes to idle, not stall.
- R14: The value written to the port-select register (offset 0x08, low PORT_W bits) reads back and drives `perPortSel`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regAddr | input | 6 | Register byte offset |
| regWrEn | input | 1 | Register write strobe |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data (combinational) |
| memEn | output | 1 | Memory access this cycle |
| memWe | output | 1 | Memory write (receive) when high |
| memAddr | output | ADDR_W | Memory byte address |
| memWdata | output | DATA_W | Word written to memory |
| memRdata | input | DATA_W | Word read from memory, same cycle |
| perReq | input | 1 | Peripheral asks for one word |
| perAck | output | 1 | Word moved this cycle |
| perWdata | output | DATA_W | Word handed to the peripheral (transmit) |
| perRdata | input | DATA_W | Word taken from the peripheral (receive) |
| perErr | input | 1 | Peripheral error pulse |
| perPortSel | output | PORT_W | Selected peripheral port |
| irq | output | 1 | Level interrupt |

## Verification
The key collision is a slot completing in the same edge as software loading the other slot. The bench drains slot 0 to zero with one final word. It then puts the slot 1 address write on the very next edge, which is the edge where slot 0 is released. It judges the result by the state still reading on, the next-buffer bit staying clear, and the next acknowledged word coming from slot 1's address. A second collision holds `perErr` high in the same cycle as a write-one-clear of the error bit, and expects the bit to survive.

// File: rtl/pdma_pkg.sv
package pdma_pkg;

  localparam int REG_DW   = 32;
  localparam int REG_AW   = 6;
  localparam int NUM_SLOT = 2;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_STALL = 2'd1,
    ST_ON    = 2'd2,
    ST_NEXT  = 2'd3
  } chanState_e;

  // control -> datapath strobes
  typedef struct packed {
    logic [NUM_SLOT-1:0] wrCnt;
    logic [NUM_SLOT-1:0] wrBase;
    logic                beat;
    logic                actSlot;
  } dpStrobe_t;

  localparam logic [REG_AW-1:0] OFS_CTRL    = 6'h00;
  localparam logic [REG_AW-1:0] OFS_INT     = 6'h04;
  localparam logic [REG_AW-1:0] OFS_PORT    = 6'h08;
  localparam logic [REG_AW-1:0] OFS_STAT    = 6'h0C;
  localparam logic [REG_AW-1:0] OFS_REMAIN  = 6'h14;
  localparam logic [REG_AW-1:0] OFS_CNT0    = 6'h20;
  localparam logic [REG_AW-1:0] OFS_BASE0   = 6'h24;
  localparam logic [REG_AW-1:0] OFS_CNT1    = 6'h30;
  localparam logic [REG_AW-1:0] OFS_BASE1   = 6'h34;
  localparam logic [REG_AW-1:0] SLOT_STRIDE = 6'h10;

  localparam int CB_STALL_IE = 0;
  localparam int CB_NEXT_IE  = 1;
  localparam int CB_ERR_IE   = 3;
  localparam int CB_EN       = 4;

  localparam int IB_STALL = 0;
  localparam int IB_NEXT  = 1;
  localparam int IB_ERR   = 3;

endpackage

// File: rtl/pdma_datapath.sv
module pdma_datapath
  import pdma_pkg::*;
#(
  parameter bit IS_RX  = 1'b0,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  dpStrobe_t                        strobe,
  input  logic [REG_DW-1:0]                wdata,
  output logic [NUM_SLOT-1:0][CNT_W-1:0]   slotRem,
  output logic [NUM_SLOT-1:0][ADDR_W-1:0]  slotAddr,
  output logic [NUM_SLOT-1:0]              remZero,
  output logic                             memEn,
  output logic                             memWe,
  output logic [ADDR_W-1:0]                memAddr,
  output logic [DATA_W-1:0]                memWdata,
  input  logic [DATA_W-1:0]                memRdata,
  output logic [DATA_W-1:0]                perWdata,
  input  logic [DATA_W-1:0]                perRdata
);

  localparam int                WORD_BYTES = DATA_W / 8;
  localparam logic [CNT_W-1:0]  STEP_C     = CNT_W'(WORD_BYTES);
  localparam logic [ADDR_W-1:0] STEP_A     = ADDR_W'(WORD_BYTES);

  for (genvar s = 0; s < NUM_SLOT; s++) begin : g_slot
    logic stepHere;
    assign stepHere = strobe.beat && (strobe.actSlot == 1'(s));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        slotRem[s] <= '0;
      end else if (strobe.wrCnt[s]) begin
        slotRem[s] <= wdata[CNT_W-1:0];
      end else if (stepHere) begin
        slotRem[s] <= (slotRem[s] > STEP_C) ? slotRem[s] - STEP_C : '0;
      end
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        slotAddr[s] <= '0;
      end else if (strobe.wrBase[s]) begin
        slotAddr[s] <= wdata[ADDR_W-1:0];
      end else if (stepHere) begin
        slotAddr[s] <= slotAddr[s] + STEP_A;
      end
    end

    assign remZero[s] = (slotRem[s] == '0);
  end

  logic [CNT_W-1:0] actRem;
  assign actRem   = slotRem[strobe.actSlot];

  assign memEn    = strobe.beat;
  assign memAddr  = slotAddr[strobe.actSlot];
  assign memWe    = IS_RX;
  assign memWdata = IS_RX ? perRdata : '0;
  assign perWdata = IS_RX ? '0 : memRdata;

  // R5: every moved word lowers the active count
  a_r5_remain_drops: assert property (@(posedge clk) disable iff (!rstN)
    strobe.beat |=> (actRem < $past(actRem)));

  // R5: every moved word advances the address by one word
  a_r5_addr_steps: assert property (@(posedge clk) disable iff (!rstN)
    strobe.beat |=> (memAddr == $past(memAddr) + STEP_A));

endmodule

// File: rtl/pdma_ctrl.sv
module pdma_ctrl
  import pdma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16,
  parameter int PORT_W = 4
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  logic [REG_AW-1:0]                regAddr,
  input  logic                             regWrEn,
  input  logic [REG_DW-1:0]                regWdata,
  output logic [REG_DW-1:0]                regRdata,
  input  logic                             perReq,
  input  logic                             perErr,
  input  logic [NUM_SLOT-1:0]              remZero,
  input  logic [NUM_SLOT-1:0][CNT_W-1:0]   slotRem,
  input  logic [NUM_SLOT-1:0][ADDR_W-1:0]  slotAddr,
  output dpStrobe_t                        strobe,
  output logic [PORT_W-1:0]                perPortSel,
  output logic                             irq
);

  logic              en, stallIe, nextIe, errIe;
  logic [PORT_W-1:0] portQ;
  chanState_e        stateQ, stateD;
  logic [NUM_SLOT-1:0] validQ, validD;
  logic              actQ, actD;
  logic              nextF, errF, stallF;

  logic wrCtrl, wrInt, wrPort;
  logic [NUM_SLOT-1:0] hitCnt, hitBase, accept, cntOk;
  logic loadOk, enNext, complete, beat, anyAccept;

  assign wrCtrl = regWrEn && (regAddr == OFS_CTRL);
  assign wrInt  = regWrEn && (regAddr == OFS_INT);
  assign wrPort = regWrEn && (regAddr == OFS_PORT);

  for (genvar s = 0; s < NUM_SLOT; s++) begin : g_slotDec
    localparam logic [REG_AW-1:0] CNT_OFS  = OFS_CNT0  + SLOT_STRIDE * REG_AW'(s);
    localparam logic [REG_AW-1:0] BASE_OFS = OFS_BASE0 + SLOT_STRIDE * REG_AW'(s);
    assign hitCnt[s]  = regWrEn && (regAddr == CNT_OFS);
    assign hitBase[s] = regWrEn && (regAddr == BASE_OFS);
  end

  assign loadOk    = en && (stateQ != ST_NEXT);
  assign accept    = hitBase & ~validQ & {NUM_SLOT{loadOk}};
  assign cntOk     = hitCnt & ~validQ;
  assign anyAccept = |accept;
  assign enNext    = wrCtrl ? regWdata[CB_EN] : en;
  assign complete  = validQ[actQ] && remZero[actQ];
  assign beat      = validQ[actQ] && !remZero[actQ] && perReq;

  always_comb begin
    validD = validQ;
    if (complete) validD[actQ] = 1'b0;
    validD = validD | accept;
  end

  always_comb begin
    actD = actQ;
    if (stateQ == ST_IDLE) actD = 1'b0;
    else if (complete)     actD = ~actQ;
  end

  always_comb begin
    stateD = stateQ;
    case (stateQ)
      ST_IDLE:  if (enNext) stateD = ST_STALL;
      ST_STALL: begin
        if (anyAccept)    stateD = ST_ON;
        else if (!enNext) stateD = ST_IDLE;
      end
      ST_ON: begin
        if (complete && !anyAccept)      stateD = enNext ? ST_STALL : ST_IDLE;
        else if (!complete && anyAccept) stateD = ST_NEXT;
      end
      ST_NEXT:  if (complete) stateD = ST_ON;
      default:  stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ  <= ST_IDLE;
      validQ  <= '0;
      actQ    <= 1'b0;
      en      <= 1'b0;
      stallIe <= 1'b0;
      nextIe  <= 1'b0;
      errIe   <= 1'b0;
      portQ   <= '0;
      nextF   <= 1'b0;
      errF    <= 1'b0;
    end else begin
      stateQ <= stateD;
      validQ <= validD;
      actQ   <= actD;
      if (wrCtrl) begin
        en      <= regWdata[CB_EN];
        stallIe <= regWdata[CB_STALL_IE];
        nextIe  <= regWdata[CB_NEXT_IE];
        errIe   <= regWdata[CB_ERR_IE];
      end
      if (wrPort) portQ <= regWdata[PORT_W-1:0];
      if (stateQ == ST_NEXT && complete)                    nextF <= 1'b1;
      else if ((wrInt && regWdata[IB_NEXT]) || anyAccept)   nextF <= 1'b0;
      if (perErr)                                           errF  <= 1'b1;
      else if (wrInt && regWdata[IB_ERR])                   errF  <= 1'b0;
    end
  end

  assign stallF = (stateQ == ST_STALL);
  assign irq    = (stallF && stallIe) || (nextF && nextIe) || (errF && errIe);
  assign perPortSel = portQ;

  always_comb begin
    regRdata = '0;
    case (regAddr)
      OFS_CTRL: begin
        regRdata[CB_EN]       = en;
        regRdata[CB_STALL_IE] = stallIe;
        regRdata[CB_NEXT_IE]  = nextIe;
        regRdata[CB_ERR_IE]   = errIe;
      end
      OFS_INT: begin
        regRdata[IB_STALL] = stallF;
        regRdata[IB_NEXT]  = nextF;
        regRdata[IB_ERR]   = errF;
      end
      OFS_PORT:   regRdata[PORT_W-1:0] = portQ;
      OFS_STAT:   regRdata[5:4]        = stateQ;
      OFS_REMAIN: regRdata[CNT_W-1:0]  = slotRem[actQ];
      OFS_CNT0:   regRdata[CNT_W-1:0]  = slotRem[0];
      OFS_BASE0:  regRdata[ADDR_W-1:0] = slotAddr[0];
      OFS_CNT1:   regRdata[CNT_W-1:0]  = slotRem[1];
      OFS_BASE1:  regRdata[ADDR_W-1:0] = slotAddr[1];
      default:    regRdata = '0;
    endcase
  end

  assign strobe.wrCnt   = cntOk;
  assign strobe.wrBase  = accept;
  assign strobe.beat    = beat;
  assign strobe.actSlot = actQ;

  // R3: state agrees with the loaded slots
  a_r3_next_both_loaded: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_NEXT) |-> (validQ == 2'b11));

  a_r3_on_one_loaded: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_ON) |-> ($countones(validQ) == 1));

  // R2: nothing moves while idle or stalled
  a_r2_quiet_states: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_IDLE || stateQ == ST_STALL) |-> (validQ == '0 && !strobe.beat));

  // R7: a completion hands service to the other slot
  a_r7_slot_flips: assert property (@(posedge clk) disable iff (!rstN)
    complete |=> (actQ != $past(actQ)));

  // R8: draining from next lands in on with the next-buffer flag raised
  a_r8_next_to_on: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_NEXT && complete) |=> (stateQ == ST_ON && nextF));

  // R9: an error always leaves the flag set
  a_r9_err_sticks: assert property (@(posedge clk) disable iff (!rstN)
    perErr |=> errF);

endmodule

// File: rtl/pdma_channel.sv
module pdma_channel
  import pdma_pkg::*;
#(
  parameter bit IS_RX  = 1'b0,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16,
  parameter int PORT_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [5:0]        regAddr,
  input  logic              regWrEn,
  input  logic [31:0]       regWdata,
  output logic [31:0]       regRdata,
  output logic              memEn,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  input  logic [DATA_W-1:0] memRdata,
  input  logic              perReq,
  output logic              perAck,
  output logic [DATA_W-1:0] perWdata,
  input  logic [DATA_W-1:0] perRdata,
  input  logic              perErr,
  output logic [PORT_W-1:0] perPortSel,
  output logic              irq
);

  dpStrobe_t                        strobe;
  logic [NUM_SLOT-1:0][CNT_W-1:0]   slotRem;
  logic [NUM_SLOT-1:0][ADDR_W-1:0]  slotAddr;
  logic [NUM_SLOT-1:0]              remZero;

  pdma_ctrl #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W), .PORT_W(PORT_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN),
    .regAddr(regAddr), .regWrEn(regWrEn), .regWdata(regWdata), .regRdata(regRdata),
    .perReq(perReq), .perErr(perErr),
    .remZero(remZero), .slotRem(slotRem), .slotAddr(slotAddr),
    .strobe(strobe), .perPortSel(perPortSel), .irq(irq)
  );

  pdma_datapath #(
    .IS_RX(IS_RX), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)
  ) u_dp (
    .clk(clk), .rstN(rstN),
    .strobe(strobe), .wdata(regWdata),
    .slotRem(slotRem), .slotAddr(slotAddr), .remZero(remZero),
    .memEn(memEn), .memWe(memWe), .memAddr(memAddr),
    .memWdata(memWdata), .memRdata(memRdata),
    .perWdata(perWdata), .perRdata(perRdata)
  );

  assign perAck = strobe.beat;

endmodule

// File: tb/pdma_channel_tb.sv
module pdma_channel_tb;

  localparam logic [5:0] A_CTRL = 6'h00, A_INT = 6'h04, A_PORT = 6'h08, A_STAT = 6'h0C,
                         A_REM = 6'h14, A_CNT0 = 6'h20, A_BASE0 = 6'h24,
                         A_CNT1 = 6'h30, A_BASE1 = 6'h34;
  localparam logic [31:0] PAT = 32'h5A5A_0000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #5 clk = ~clk;

  // transmit instance
  logic [5:0]  regAddr = '0;
  logic        regWrEn = 1'b0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic        memEn, memWe;
  logic [31:0] memAddr, memWdata, memRdata, perWdata;
  logic        perReq = 1'b0, perAck, perErr = 1'b0, irq;
  logic [31:0] perRdata = '0;
  logic [3:0]  perPortSel;

  assign memRdata = memAddr ^ PAT;

  pdma_channel #(.IS_RX(1'b0)) u_dut (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn), .regWdata(regWdata),
    .regRdata(regRdata), .memEn(memEn), .memWe(memWe), .memAddr(memAddr),
    .memWdata(memWdata), .memRdata(memRdata), .perReq(perReq), .perAck(perAck),
    .perWdata(perWdata), .perRdata(perRdata), .perErr(perErr),
    .perPortSel(perPortSel), .irq(irq)
  );

  // receive instance
  logic [5:0]  rxAddr = '0;
  logic        rxWrEn = 1'b0;
  logic [31:0] rxWdata = '0;
  logic [31:0] rxRdata;
  logic        rxMemEn, rxMemWe, rxAck, rxIrq;
  logic [31:0] rxMemAddr, rxMemWdata, rxPerWdata;
  logic        rxReq = 1'b0;
  logic [31:0] rxPerRdata = '0;
  logic [3:0]  rxPortSel;

  pdma_channel #(.IS_RX(1'b1)) u_dutRx (
    .clk(clk), .rstN(rstN), .regAddr(rxAddr), .regWrEn(rxWrEn), .regWdata(rxWdata),
    .regRdata(rxRdata), .memEn(rxMemEn), .memWe(rxMemWe), .memAddr(rxMemAddr),
    .memWdata(rxMemWdata), .memRdata(32'h0), .perReq(rxReq), .perAck(rxAck),
    .perWdata(rxPerWdata), .perRdata(rxPerRdata), .perErr(1'b0),
    .perPortSel(rxPortSel), .irq(rxIrq)
  );

  int nChecks = 0;
  int nBad = 0;
  bit done = 1'b0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // all tasks start and end at a falling edge
  task automatic regWrite(input logic [5:0] a, input logic [31:0] d);
    regAddr = a; regWdata = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic chkReg(input string tag, input logic [5:0] a, input logic [31:0] exp);
    regAddr = a;
    #1 chk(tag, regRdata, exp);
    @(negedge clk);
  endtask

  task automatic beat(input string tag, input logic [31:0] expAddr, input bit expAck);
    perReq = 1'b1;
    #1;
    chk({tag, " ack"}, {31'b0, perAck}, {31'b0, expAck});
    if (expAck) begin
      chk({tag, " memEn"}, {31'b0, memEn}, 32'd1);
      chk({tag, " addr"}, memAddr, expAddr);
      chk({tag, " R6 memWe"}, {31'b0, memWe}, 32'd0);
      chk({tag, " R6 perWdata"}, perWdata, expAddr ^ PAT);
    end
    @(negedge clk);
    perReq = 1'b0;
  endtask

  task automatic t_reset;
    chkReg("R1 status", A_STAT, 32'h0);
    chkReg("R1 int", A_INT, 32'h0);
    chkReg("R1 ctrl", A_CTRL, 32'h0);
    chkReg("R1 remain", A_REM, 32'h0);
    chk("R1 irq", {31'b0, irq}, 32'd0);
    beat("R1 R2 idle no ack", 32'h0, 1'b0);
  endtask

  task automatic t_enable;
    regWrite(A_CTRL, 32'h10);
    chkReg("R2 idle->stall", A_STAT, 32'h10);
    chkReg("R8 stall bit", A_INT, 32'h1);
    chk("R10 masked stall", {31'b0, irq}, 32'd0);
    regWrite(A_CTRL, 32'h11);
    chk("R10 stall irq", {31'b0, irq}, 32'd1);
    beat("R2 stall no ack", 32'h0, 1'b0);
    regWrite(A_CTRL, 32'h12);
  endtask

  task automatic t_load_xfer;
    regWrite(A_CNT0, 32'd8);
    regWrite(A_BASE0, 32'h100);
    chkReg("R3 stall->on", A_STAT, 32'h20);
    chkReg("R5 remain loaded", A_REM, 32'd8);
    regWrite(A_CNT1, 32'd4);
    regWrite(A_BASE1, 32'h200);
    chkReg("R3 on->next", A_STAT, 32'h30);
    regWrite(A_BASE0, 32'h300);
    chkReg("R3 next ignores load", A_STAT, 32'h30);
    regWrite(A_CNT0, 32'd40);
    chkReg("R4 count guarded", A_REM, 32'd8);
    beat("R5 word0", 32'h100, 1'b1);
    chkReg("R5 remain step", A_REM, 32'd4);
    beat("R5 word1", 32'h104, 1'b1);
    chkReg("R5 remain zero", A_REM, 32'd0);
    chkReg("R8 next->on", A_STAT, 32'h20);
    chkReg("R8 next flag", A_INT, 32'h2);
    chk("R10 next irq", {31'b0, irq}, 32'd1);
    chkReg("R7 slot1 remain", A_REM, 32'd4);
    regWrite(A_INT, 32'h2);
    chkReg("R11 w1c next", A_INT, 32'h0);
    chk("R10 irq drops", {31'b0, irq}, 32'd0);
    beat("R7 slot1 word", 32'h200, 1'b1);
    @(negedge clk);
    chkReg("R8 on->stall", A_STAT, 32'h10);
    chkReg("R8 stall only", A_INT, 32'h1);
  endtask

  task automatic t_collision;
    regWrite(A_CNT0, 32'd4);
    regWrite(A_BASE0, 32'h400);
    regWrite(A_CNT1, 32'd6);
    beat("R12 last word", 32'h400, 1'b1);
    regWrite(A_BASE1, 32'h500);
    chkReg("R12 stays on", A_STAT, 32'h20);
    chkReg("R12 no next flag", A_INT, 32'h0);
    chkReg("R12 new remain", A_REM, 32'd6);
    beat("R12 R7 next slot", 32'h500, 1'b1);
    beat("R5 partial word", 32'h504, 1'b1);
    chkReg("R5 saturates", A_REM, 32'd0);
    chkReg("R8 drained", A_STAT, 32'h10);
  endtask

  task automatic t_error;
    regWrite(A_CTRL, 32'h18);
    perErr = 1'b1;
    @(negedge clk);
    perErr = 1'b0;
    chkReg("R9 err set", A_INT, 32'h9);
    chk("R10 err irq", {31'b0, irq}, 32'd1);
    perErr = 1'b1;
    regWrite(A_INT, 32'h8);
    perErr = 1'b0;
    chkReg("R9 set wins", A_INT, 32'h9);
    regWrite(A_INT, 32'h8);
    chkReg("R9 w1c", A_INT, 32'h1);
    chk("R10 irq clear", {31'b0, irq}, 32'd0);
  endtask

  task automatic t_drain;
    regWrite(A_CNT0, 32'd4);
    regWrite(A_BASE0, 32'h600);
    regWrite(A_CTRL, 32'h00);
    chkReg("R13 still on", A_STAT, 32'h20);
    regWrite(A_CNT1, 32'd4);
    regWrite(A_BASE1, 32'h700);
    chkReg("R3 disabled load ignored", A_STAT, 32'h20);
    beat("R13 drain word", 32'h600, 1'b1);
    @(negedge clk);
    chkReg("R13 idle after drain", A_STAT, 32'h00);
    regWrite(A_CTRL, 32'h10);
    chkReg("R2 re-enable", A_STAT, 32'h10);
    regWrite(A_CNT0, 32'd4);
    regWrite(A_BASE0, 32'h800);
    beat("R7 slot0 first", 32'h800, 1'b1);
    @(negedge clk);
    chkReg("R8 back to stall", A_STAT, 32'h10);
  endtask

  task automatic t_port;
    regWrite(A_PORT, 32'h5);
    chk("R14 port pin", {28'b0, perPortSel}, 32'h5);
    chkReg("R14 port read", A_PORT, 32'h5);
  endtask

  task automatic t_rx;
    rxAddr = A_CTRL; rxWdata = 32'h10; rxWrEn = 1'b1; @(negedge clk);
    rxAddr = A_CNT0; rxWdata = 32'd4;              @(negedge clk);
    rxAddr = A_BASE0; rxWdata = 32'h900;           @(negedge clk);
    rxWrEn = 1'b0;
    rxPerRdata = 32'hCAFE_0001;
    rxReq = 1'b1;
    #1;
    chk("R6 rx ack", {31'b0, rxAck}, 32'd1);
    chk("R6 rx memWe", {31'b0, rxMemWe}, 32'd1);
    chk("R6 rx data", rxMemWdata, 32'hCAFE_0001);
    chk("R6 rx addr", rxMemAddr, 32'h900);
    @(negedge clk);
    rxReq = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_enable();
    t_load_xfer();
    t_collision();
    t_error();
    t_drain();
    t_port();
    t_rx();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", nChecks, nBad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nBad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", nChecks, nBad);
      $finish;
    end
  end

endmodule